// File: doc/BRIEF.md
# Two-Wire Serial Byte-Store Slave

This block is a slave on a two-wire serial bus (I2C) that fronts a 256-location by 8-bit storage array. A faster system clock oversamples the bus clock and data lines. The block drives the data line as open drain through a single enable that pulls the line low. A master opens a transfer with a START condition and then sends a 7-bit device address. The upper four address bits are a fixed prefix (default 1010), and the lower three must match the strap inputs. The block then answers write transfers, in which a byte address is followed by any number of data bytes, and read transfers, which stream bytes out for as long as the master acknowledges each one.

An internal byte pointer tracks the current location. It moves forward after every byte stored or sent and wraps at the top of the array. A read that is not preceded by a byte-address write therefore continues from wherever the pointer was left. A random read is a byte-address write followed by a repeated START in read direction. While the write-protect input is high, data bytes are still acknowledged but nothing is stored. A STOP that closes a write which stored at least one byte starts a write-cycle countdown of `WCYCLE_CYC` system clocks. Until the countdown ends the block refuses its own address, so a master can poll for readiness.

The bus is a bit-serial control protocol with its own acknowledge handshake, so the block has no valid/ready stream edge: back-pressure is the NoACK the block returns during the write cycle. The bus clock must stay low for longer than `SYNC_STAGES + 2` system clocks so the block can settle its output while the clock is low.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. Before the first START, and again after a STOP, clocked bits are ignored and never acknowledged.
- R2: The block acknowledges, by pulling data low in the ninth clock, an address byte whose bits 7..4 equal `DEV_PREFIX` and whose bits 3..1 equal `strap_i`. It does not acknowledge any other address byte, and it acknowledges none while a write cycle runs. Bit 0 = 0 selects write and bit 0 = 1 selects read.
- R3: In a write transfer the block acknowledges the byte-address byte and every data byte. Each data byte is stored at the pointer, after which the pointer increments and wraps from 255 to 0.
- R4: In a read transfer the block sends the byte at the pointer MSB first, then increments the pointer. It sends the next byte after a master ACK (data low in the ninth clock). After a NoACK it releases data and sends nothing more until the next START.
- R5: A byte-address write followed by a repeated START in read direction reads from that address. A read with no preceding byte-address write starts from the stored pointer.
- R6: While `wp_i` is high, data bytes are acknowledged and advance the pointer, but the storage is left unchanged and no write cycle is started.
- R7: A STOP that closes a write in which at least one byte was stored starts a busy interval of `WCYCLE_CYC` system clocks. After the interval the address is acknowledged again.
- R8: A START that arrives in the middle of a byte restarts address decoding from the first bit.
- R9: The data output changes only while the bus clock is low.
- R10: After reset the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect, high blocks stores |

## Verification
The bench builds the block with the default 8-bit address width, so the whole 256-location array is written and read back in single transfers. This exposes pointer wrap in both directions. `WCYCLE_CYC` is cut to 300 so that a poll during the busy interval and a poll after it both fit in a short run. Every write-direction 7-bit address is probed against one strap setting, and every strap setting is crossed with all eight prefixed addresses. Expected data is an arithmetic pattern of the location index.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WORD,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } eep_phase_e;
endpackage

// File: rtl/eep_bus_front.sv
module eep_bus_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_pipe;
  logic [TOP:0] sda_pipe;
  logic         scl_d;
  logic         sda_d;
  logic         scl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        scl_pipe[k] <= scl_pipe[k-1];
        sda_pipe[k] <= sda_pipe[k-1];
      end
      scl_d <= scl_pipe[TOP];
      sda_d <= sda_pipe[TOP];
    end
  end

  assign scl_s     = scl_pipe[TOP];
  assign sda_s     = sda_pipe[TOP];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_wcycle_timer.sv
module eep_wcycle_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start_i) begin
      remain <= CW'(CYCLES);
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign busy_o = (remain != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter logic [3:0] DEV_PREFIX  = 4'b1010,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         WCYCLE_CYC  = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import eep_pkg::*;

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_BITS);

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wc_busy, wc_start;

  eep_phase_e           phase;
  logic [CNT_W-1:0]     bit_cnt;
  logic [BYTE_BITS-1:0] shreg;
  logic [BYTE_BITS-1:0] tx;
  logic [ADDR_W-1:0]    ptr;
  logic                 ack_q;
  logic                 dirty_q;

  logic                 dev_match;
  logic                 mem_we;
  logic [ADDR_W-1:0]    rd_addr;
  logic [BYTE_BITS-1:0] rd_data;
  logic                 bus_event;

  eep_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  eep_wcycle_timer #(.CYCLES(WCYCLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wc_start),
    .busy_o  (wc_busy)
  );

  eep_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_BITS)) u_store (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (ptr),
    .wdata_i (shreg),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  assign bus_event = start_evt | stop_evt;
  assign dev_match = (shreg[7:4] == DEV_PREFIX) && (shreg[3:1] == strap_i);
  assign wc_start  = stop_evt & dirty_q;
  assign rd_addr   = (phase == PH_RDATA) ? ptr + ADDR_W'(1) : ptr;
  assign mem_we    = !bus_event && scl_rise && (phase == PH_WDATA)
                     && (bit_cnt == ACK_SLOT) && !wp_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      ack_q    <= 1'b0;
      dirty_q  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_evt) begin
      phase    <= PH_DEV;
      bit_cnt  <= '0;
      ack_q    <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_evt) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      dirty_q  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (phase != PH_IDLE && phase != PH_IGNORE) begin
      if (scl_rise) begin
        if (bit_cnt != ACK_SLOT) begin
          shreg   <= {shreg[BYTE_BITS-2:0], sda_s};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end else begin
          bit_cnt <= '0;
          unique case (phase)
            PH_DEV: begin
              if (!ack_q)        phase <= PH_IGNORE;
              else if (shreg[0]) begin
                phase <= PH_RDATA;
                tx    <= rd_data;
              end else           phase <= PH_WORD;
            end
            PH_WORD: begin
              ptr   <= shreg[ADDR_W-1:0];
              phase <= PH_WDATA;
            end
            PH_WDATA: begin
              ptr <= ptr + ADDR_W'(1);
              if (!wp_i) dirty_q <= 1'b1;
            end
            PH_RDATA: begin
              ptr <= ptr + ADDR_W'(1);
              if (!sda_s) tx <= rd_data;
              else        phase <= PH_IGNORE;
            end
            default: phase <= PH_IGNORE;
          endcase
        end
      end else if (scl_fall) begin
        if (bit_cnt == ACK_SLOT) begin
          unique case (phase)
            PH_DEV: begin
              ack_q    <= dev_match & ~wc_busy;
              sda_oe_o <= dev_match & ~wc_busy;
            end
            PH_WORD, PH_WDATA: sda_oe_o <= 1'b1;
            default:           sda_oe_o <= 1'b0;
          endcase
        end else if (phase == PH_RDATA) begin
          sda_oe_o <= ~tx[3'(3'd7 - bit_cnt[2:0])];
        end else begin
          sda_oe_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_i,
  input logic                sda_oe_o,
  input logic                start_evt,
  input logic                stop_evt,
  input logic                wc_busy,
  input eep_pkg::eep_phase_e phase
);
  import eep_pkg::*;

  // R1
  start_enters_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_DEV));

  // R2
  no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEV && sda_oe_o) |-> !wc_busy);

  // R4
  ignore_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> !sda_oe_o);

  // R7
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wc_busy) |-> $past(stop_evt));

  // R9
  drive_on_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R10
  reset_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sda_oe_o);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .wc_busy   (wc_busy),
  .phase     (phase)
);

// File: tb/test_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module test_i2c_eeprom_slave;
  localparam int WCYC = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd5;
  logic       wp = 1'b0;
  logic       sda_oe;
  logic       sda_bus;
  int         checks = 0;
  int         fails = 0;

  assign sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_eeprom_slave #(.WCYCLE_CYC(WCYC)) i_i2c_eeprom_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .strap_i  (strap),
    .wp_i     (wp)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tk(8);
    scl = 1'b1;   tk(8);
    sda_m = 1'b0; tk(8);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    tk(4); sda_m = 1'b0; tk(4);
    scl = 1'b1; tk(8);
    sda_m = 1'b1; tk(8);
  endtask

  task automatic put_bit(logic b);
    tk(4); sda_m = b; tk(4);
    scl = 1'b1; tk(8);
    scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tk(8);
    scl = 1'b1; tk(4);
    b = sda_bus; tk(4);
    scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d, output logic acked);
    logic b;
    for (int k = 7; k >= 0; k--) put_bit(d[k]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(logic master_ack, output logic [7:0] d);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      get_bit(b);
      d[k] = b;
    end
    put_bit(~master_ack);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         all_ack;

    tk(5);
    chk("R10 released during reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tk(5);
    chk("R10 released after reset", int'(sda_oe), 0);

    // R1: traffic with no START is ignored
    scl = 1'b0; tk(4);
    send_byte(8'hAA, ack);
    chk("R1 no start no ack", int'(ack), 0);
    bus_stop();

    // R2: sweep all write-direction addresses, strap = 5
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk("R2 address sweep", int'(ack), int'(a == 7'b1010101));
      bus_stop();
    end

    // R2: every strap setting against every prefixed address
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        send_byte({4'b1010, 3'(a), 1'b0}, ack);
        chk("R2 strap sweep", int'(ack), int'(a == s));
        bus_stop();
      end
    end
    strap = 3'd5;

    // R3: fill all locations from 0 in one transfer
    bus_start();
    send_byte(8'hAA, ack);
    chk("R3 dev ack", int'(ack), 1);
    send_byte(8'h00, ack);
    chk("R3 byte address ack", int'(ack), 1);
    all_ack = 1;
    for (int i = 0; i < 256; i++) begin
      send_byte(pat(i), ack);
      if (!ack) all_ack = 0;
    end
    chk("R3 every data byte acked", all_ack, 1);
    bus_stop();

    // R7: busy right after STOP, ready after interval
    bus_start();
    send_byte(8'hAA, ack);
    chk("R7 busy poll nack", int'(ack), 0);
    bus_stop();
    tk(WCYC);
    bus_start();
    send_byte(8'hAA, ack);
    chk("R7 ready after cycle", int'(ack), 1);
    bus_stop();

    // R5 random read across the wrap, R4 ack continues, NoACK ends
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(8'hAB, ack);
    chk("R5 read dev ack", int'(ack), 1);
    recv_byte(1'b1, d); chk("R5 random read FE", int'(d), int'(pat(254)));
    recv_byte(1'b1, d); chk("R4 seq read FF", int'(d), int'(pat(255)));
    recv_byte(1'b1, d); chk("R3 wrap read 00", int'(d), int'(pat(0)));
    recv_byte(1'b0, d); chk("R4 seq read 01", int'(d), int'(pat(1)));
    tk(6);
    chk("R4 released after noack", int'(sda_oe), 0);
    tk(8);
    chk("R4 still released", int'(sda_bus), 1);
    bus_stop();

    // R5 current-address read continues from pointer
    bus_start();
    send_byte(8'hAB, ack);
    recv_byte(1'b0, d);
    chk("R5 current address read", int'(d), int'(pat(2)));
    bus_stop();

    // R4: full sequential read of all locations
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'h00, ack);
    bus_start();
    send_byte(8'hAB, ack);
    for (int i = 0; i < 256; i++) begin
      recv_byte(i != 255, d);
      chk("R4 full read", int'(d), int'(pat(i)));
    end
    bus_stop();

    // R6: write protect
    wp = 1'b1;
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'h10, ack);
    send_byte(8'h55, ack);
    chk("R6 protected byte acked", int'(ack), 1);
    send_byte(8'h66, ack);
    bus_stop();
    wp = 1'b0;
    bus_start();
    send_byte(8'hAA, ack);
    chk("R6 no write cycle", int'(ack), 1);
    send_byte(8'h10, ack);
    bus_start();
    send_byte(8'hAB, ack);
    recv_byte(1'b1, d); chk("R6 location 10 kept", int'(d), int'(pat(16)));
    recv_byte(1'b0, d); chk("R6 location 11 kept", int'(d), int'(pat(17)));
    bus_stop();

    // R8: START in the middle of a byte restarts decoding
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send_byte(8'hAB, ack);
    chk("R8 restart ack", int'(ack), 1);
    recv_byte(1'b0, d);
    chk("R8 restart read", int'(d), int'(pat(18)));
    bus_stop();

    // R1: after STOP, clocked bits ignored again
    scl = 1'b0; tk(4);
    send_byte(8'hAA, ack);
    chk("R1 after stop no ack", int'(ack), 0);
    bus_stop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule